// File: doc/BRIEF.md
# Slave Handshake and Status Controller

This block runs the slave side of a half-duplex link where only the master can start a transfer. A command decoder in front of it turns the master's traffic into single-cycle events: a send request with its 32-bit info word, a write-done, and a read-done. Local logic raises a transmit request when it has a packet waiting for the master. The block answers through a status word that the decoder returns to status queries, and through a sideband handshake line that the master watches for rising edges.

A send request is honoured only when its top byte holds the magic value. When honoured, the status word is first set to the writable state, and the handshake line rises one cycle later. A local transmit request is announced the same way with the readable state, the outgoing length and the outgoing sequence number. The line drops when the matching done event arrives. Outgoing sequence numbers advance by one per delivered packet and wrap at 8 bits. A master write request wins over a local transmit request, and the local one is served once the block is idle again.

Top module: `hs_status_ctrl`

## Requirements
- R1: After reset the handshake line is low, the status word is 0 and the transmit acknowledge is low.
- R2: A send request whose info bits 31:24 equal 0xFE, seen while idle, sets the status word to {0x02, info bits 23:16, 16'h0000} at the next clock edge with the handshake still low. The handshake rises at the edge after that.
- R3: A send request whose bits 31:24 differ from 0xFE is ignored. The status word and the handshake stay unchanged.
- R4: A write-done event while the writable handshake is high lowers the handshake at the next edge. It also sets the state code (bits 31:24) and the length (bits 15:0) of the status word to 0.
- R5: A transmit request seen while idle pulses the transmit acknowledge for one cycle. At the same edge the status word becomes {0x01, outgoing sequence number, transmit length}, and the handshake rises one edge later.
- R6: A read-done event while the readable handshake is high lowers the handshake and zeroes the state code and the length at the next edge. It also advances the outgoing sequence number by one. The first packet after reset carries number 0.
- R7: The outgoing sequence number wraps from 0xFF to 0x00.
- R8: When a valid send request and a transmit request are both present in the same idle cycle, the write is granted first. The transmit is announced in the cycle after the write-done returns the block to idle.
- R9: A done event that does not match the current exchange is ignored, and so is any done event while idle. Send and transmit requests arriving during an exchange are also ignored. In each case the status word and the handshake do not change.
- R10: The handshake is high only while the state code is 0x01 or 0x02, and it never rises in the same cycle that the status word changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded send-request event (one cycle) |
| req_info | input | 32 | Request info word: length 15:0, sequence 23:16, magic 31:24 |
| wr_done | input | 1 | Decoded write-done event |
| rd_done | input | 1 | Decoded read-done event |
| tx_req | input | 1 | Local packet waiting for the master (level) |
| tx_len | input | 16 | Length of the waiting packet |
| tx_ack | output | 1 | One-cycle pulse when the waiting packet is announced |
| hs | output | 1 | Handshake line to the master |
| status | output | 32 | Status word: length 15:0, sequence 23:16, state code 31:24 |

## Verification
The write path is driven with several request sequence numbers to show that the writable status echoes the request's number and keeps the length at zero. A bad magic byte shows that validation gates the grant. The read path runs with varying lengths and many packets in a row, so the sequence counter is seen to start at zero, step by one and wrap past 0xFF. Mismatched done events and requests during an exchange separate a correct exchange tracker from one that reacts to any event. A simultaneous write and transmit request shows whether the arbitration order is right.

// File: rtl/hs_status_ctrl.sv
module hs_status_ctrl #(
  parameter int LEN_W = 16,
  parameter int TAG_W = 8,
  parameter logic [TAG_W-1:0] MAGIC = 8'hFE
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [LEN_W+2*TAG_W-1:0] req_info,
  input  logic                     wr_done,
  input  logic                     rd_done,
  input  logic                     tx_req,
  input  logic [LEN_W-1:0]         tx_len,
  output logic                     tx_ack,
  output logic                     hs,
  output logic [LEN_W+2*TAG_W-1:0] status
);
  localparam int WORD_W = LEN_W + 2*TAG_W;
  localparam logic [TAG_W-1:0] CODE_IDLE = TAG_W'(0);
  localparam logic [TAG_W-1:0] CODE_RD   = TAG_W'(1);
  localparam logic [TAG_W-1:0] CODE_WR   = TAG_W'(2);

  typedef enum logic [2:0] {S_IDLE, S_WR_PREP, S_WR_WAIT, S_RD_PREP, S_RD_WAIT} st_t;

  st_t              st;
  logic [TAG_W-1:0] tx_seq;

  wire              req_ok  = req_valid && (req_info[WORD_W-1 -: TAG_W] == MAGIC);
  wire [TAG_W-1:0]  req_seq = req_info[LEN_W +: TAG_W];
  wire [TAG_W-1:0]  cur_seq = status[LEN_W +: TAG_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      hs     <= 1'b0;
      status <= '0;
      tx_seq <= '0;
      tx_ack <= 1'b0;
    end else begin
      tx_ack <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_ok) begin
            st     <= S_WR_PREP;
            status <= {CODE_WR, req_seq, {LEN_W{1'b0}}};
          end else if (tx_req) begin
            st     <= S_RD_PREP;
            status <= {CODE_RD, tx_seq, tx_len};
            tx_ack <= 1'b1;
          end
        end
        S_WR_PREP: begin
          st <= S_WR_WAIT;
          hs <= 1'b1;
        end
        S_WR_WAIT: begin
          if (wr_done) begin
            st     <= S_IDLE;
            hs     <= 1'b0;
            status <= {CODE_IDLE, cur_seq, {LEN_W{1'b0}}};
          end
        end
        S_RD_PREP: begin
          st <= S_RD_WAIT;
          hs <= 1'b1;
        end
        S_RD_WAIT: begin
          if (rd_done) begin
            st     <= S_IDLE;
            hs     <= 1'b0;
            status <= {CODE_IDLE, cur_seq, {LEN_W{1'b0}}};
            tx_seq <= tx_seq + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hs_status_ctrl_chk.sv
module hs_status_ctrl_chk #(
  parameter int LEN_W = 16,
  parameter int TAG_W = 8,
  parameter logic [TAG_W-1:0] MAGIC = 8'hFE
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic [LEN_W+2*TAG_W-1:0] req_info,
  input logic                     wr_done,
  input logic                     rd_done,
  input logic                     tx_req,
  input logic                     tx_ack,
  input logic                     hs,
  input logic [LEN_W+2*TAG_W-1:0] status
);
  localparam int WORD_W = LEN_W + 2*TAG_W;
  wire [TAG_W-1:0] code  = status[WORD_W-1 -: TAG_W];
  wire [TAG_W-1:0] seq   = status[LEN_W +: TAG_W];
  wire             idle  = !hs && code == '0;
  wire             magic = req_info[WORD_W-1 -: TAG_W] == MAGIC;

  logic [TAG_W-1:0] exp_seq;
  always_ff @(posedge clk) begin
    if (!rst_n) exp_seq <= '0;
    else if (hs && code == TAG_W'(1) && rd_done) exp_seq <= exp_seq + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) $rose(rst_n) |-> !hs && status == '0 && !tx_ack);

  // R2
  wr_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req_valid && magic |=> code == TAG_W'(2) && !hs && seq == $past(req_info[LEN_W +: TAG_W]));

  // R3
  bad_magic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req_valid && !magic && !tx_req |=> idle && !tx_ack);

  // R4
  wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && code == TAG_W'(2) && wr_done |=> !hs && code == '0 && status[LEN_W-1:0] == '0);

  // R6
  rd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && code == TAG_W'(1) && rd_done |=> !hs && code == '0 && status[LEN_W-1:0] == '0);

  // R5
  tx_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |-> code == TAG_W'(1) && !hs && seq == exp_seq);

  // R8
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && req_valid && magic && tx_req |=> code == TAG_W'(2) && !tx_ack);

  // R10
  hs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> code == TAG_W'(1) || code == TAG_W'(2));

  // R10
  hs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs) |-> $stable(status));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs && code == TAG_W'(2) && !wr_done |=> hs && $stable(status));
endmodule

bind hs_status_ctrl hs_status_ctrl_chk #(.LEN_W(LEN_W), .TAG_W(TAG_W), .MAGIC(MAGIC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_info(req_info),
  .wr_done(wr_done), .rd_done(rd_done), .tx_req(tx_req), .tx_ack(tx_ack),
  .hs(hs), .status(status)
);

// File: tb/hs_status_ctrl_bench.sv
`timescale 1ns/1ps
module hs_status_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_info = '0;
  logic        wr_done = 1'b0;
  logic        rd_done = 1'b0;
  logic        tx_req = 1'b0;
  logic [15:0] tx_len = '0;
  logic        tx_ack;
  logic        hs;
  logic [31:0] status;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_seq = 8'h00;
  logic [7:0] last_seq = 8'h00;

  always #2 clk = ~clk;

  hs_status_ctrl u_hs_status_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_info(req_info),
    .wr_done(wr_done), .rd_done(rd_done), .tx_req(tx_req), .tx_len(tx_len),
    .tx_ack(tx_ack), .hs(hs), .status(status)
  );

  task automatic check(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input logic e_hs, input logic e_ack, input logic [31:0] e_st);
    check(hs === e_hs && tx_ack === e_ack && status === e_st, tag,
          {hs, tx_ack, status}, {e_hs, e_ack, e_st});
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] sq);
    req_info = {8'hFE, sq, 16'h1234};
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    chk_state("R2", 1'b0, 1'b0, {8'h02, sq, 16'h0000});
    tick();
    chk_state("R2", 1'b1, 1'b0, {8'h02, sq, 16'h0000});
    tick();
    wr_done = 1'b1;
    tick();
    wr_done = 1'b0;
    chk_state("R4", 1'b0, 1'b0, {8'h00, sq, 16'h0000});
    last_seq = sq;
  endtask

  task automatic do_read(input logic [15:0] ln);
    tx_len = ln;
    tx_req = 1'b1;
    tick();
    tx_req = 1'b0;
    chk_state("R5", 1'b0, 1'b1, {8'h01, exp_seq, ln});
    tick();
    chk_state("R5", 1'b1, 1'b0, {8'h01, exp_seq, ln});
    rd_done = 1'b1;
    tick();
    rd_done = 1'b0;
    chk_state("R6", 1'b0, 1'b0, {8'h00, exp_seq, 16'h0000});
    last_seq = exp_seq;
    exp_seq = exp_seq + 8'h01;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk_state("R1", 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_bad_magic();
    req_info = {8'hEF, 8'h33, 16'h0040};
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    chk_state("R3", 1'b0, 1'b0, {8'h00, last_seq, 16'h0000});
    tick();
    chk_state("R3", 1'b0, 1'b0, {8'h00, last_seq, 16'h0000});
  endtask

  task automatic t_ignored();
    wr_done = 1'b1; rd_done = 1'b1;
    tick();
    wr_done = 1'b0; rd_done = 1'b0;
    chk_state("R9", 1'b0, 1'b0, {8'h00, last_seq, 16'h0000});
    req_info = {8'hFE, 8'h5A, 16'h0000};
    req_valid = 1'b1;
    tick();
    req_valid = 1'b0;
    tick();
    rd_done = 1'b1;
    req_info = {8'hFE, 8'h77, 16'h0000};
    req_valid = 1'b1;
    tx_req = 1'b1;
    tick();
    rd_done = 1'b0; req_valid = 1'b0; tx_req = 1'b0;
    chk_state("R9", 1'b1, 1'b0, {8'h02, 8'h5A, 16'h0000});
    tick();
    chk_state("R9", 1'b1, 1'b0, {8'h02, 8'h5A, 16'h0000});
    wr_done = 1'b1;
    tick();
    wr_done = 1'b0;
    chk_state("R4", 1'b0, 1'b0, {8'h00, 8'h5A, 16'h0000});
    tick();
    chk_state("R9", 1'b0, 1'b0, {8'h00, 8'h5A, 16'h0000});
    tx_len = 16'h0010;
    tx_req = 1'b1;
    tick();
    tx_req = 1'b0;
    tick();
    wr_done = 1'b1;
    tick();
    wr_done = 1'b0;
    chk_state("R9", 1'b1, 1'b0, {8'h01, exp_seq, 16'h0010});
    rd_done = 1'b1;
    tick();
    rd_done = 1'b0;
    chk_state("R6", 1'b0, 1'b0, {8'h00, exp_seq, 16'h0000});
    last_seq = exp_seq;
    exp_seq = exp_seq + 8'h01;
  endtask

  task automatic t_priority();
    req_info = {8'hFE, 8'hC3, 16'h0008};
    req_valid = 1'b1;
    tx_len = 16'h0777;
    tx_req = 1'b1;
    tick();
    req_valid = 1'b0;
    chk_state("R8", 1'b0, 1'b0, {8'h02, 8'hC3, 16'h0000});
    tick(); tick();
    chk_state("R8", 1'b1, 1'b0, {8'h02, 8'hC3, 16'h0000});
    wr_done = 1'b1;
    tick();
    wr_done = 1'b0;
    chk_state("R8", 1'b0, 1'b0, {8'h00, 8'hC3, 16'h0000});
    tick();
    tx_req = 1'b0;
    chk_state("R8", 1'b0, 1'b1, {8'h01, exp_seq, 16'h0777});
    tick();
    chk_state("R8", 1'b1, 1'b0, {8'h01, exp_seq, 16'h0777});
    rd_done = 1'b1;
    tick();
    rd_done = 1'b0;
    chk_state("R6", 1'b0, 1'b0, {8'h00, exp_seq, 16'h0000});
    last_seq = exp_seq;
    exp_seq = exp_seq + 8'h01;
  endtask

  task automatic t_wrap();
    while (exp_seq != 8'hFF) do_read(16'(exp_seq) + 16'h0100);
    do_read(16'h0FFC);
    check(exp_seq == 8'h00, "R7", {26'h0, exp_seq}, 34'h0);
    do_read(16'h0002);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    do_read(16'h0020);
    do_write(8'h11);
    do_write(8'hFF);
    t_bad_magic();
    do_read(16'hFFFF);
    t_ignored();
    t_priority();
    t_wrap();
    do_write(8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule